// File: doc/BRIEF.md
# Light-Load Pulse-on-Demand Buck Sequencer

This block drives the high-side and low-side switch enables of a synchronous buck converter. At light load it delivers energy in single pulses, and only when they are needed. When the output-low comparator reports a sagging output, a counter-based minimum-on one-shot turns the high side on for a fixed number of clock cycles. The high side then hands over to the low side after a one-cycle dead gap. The low side conducts until the zero-current comparator fires, and then both switches rest until the output sags again. The on-time is not a plain programmed count: it grows as the programmed headroom code (input minus output voltage) falls. If the over-current comparator trips during a pulse, the high side is cut. It stays off for a programmable minimum-off window and is then relaunched.

A full-load mode bypasses the one-shot path. In that mode the output-low comparator alone chooses the conducting switch, with a dead gap at each change. The output ripple then follows the comparator hysteresis. An under-voltage lockout flag overrides everything. All comparator flags are asynchronous and are brought into the clock domain by two-flop synchronizers. The switch enables and a 3-bit state code are decoded from one state register.

Top module: `pod_sequencer`

## Requirements
- R1: After reset the state code is 0 (rest) and both switch enables are low.
- R2: In light-load mode, a sag seen at rest turns the high side on for exactly max(1, base + (2^HW-1 - headroom)) cycles, where base is ton_base_i and headroom is headroom_i.
- R3: When the on-time expires, one cycle follows with both enables low (state code 2), and then the low side turns on (state code 3).
- R4: The low side stays on until the zero-current flag is seen. The block then returns to rest (code 0) with both enables low and stays there while no sag is reported.
- R5: An over-current flag seen during the on-time cuts the high side at once (state code 4) for max(1, toff_i) cycles. The high side is then relaunched with a fresh full on-time. If over-current and on-time expiry fall in the same cycle, over-current wins.
- R6: In full-load mode the high side is on (code 5) while sag is reported and the low side is on (code 6) while it is not. Each change passes through one cycle with both enables low (code 7). Leaving full-load mode returns the block to rest.
- R7: While lockout is seen, the block is at rest with both enables low in every state, whatever the other flags do. When lockout is released with sag present, a new pulse starts.
- R8: Every flag passes through a two-flop synchronizer. A flag change driven between clock edges takes effect on the state and enables after the third rising edge.
- R9: The two switch enables are never high in the same cycle, and a switch never turns on in the cycle after the other one was on.
- R10: The on-time is captured when the pulse starts. A change of headroom or base during a running pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sag_i | input | 1 | Output-low comparator flag (asynchronous) |
| zc_i | input | 1 | Inductor zero-current flag (asynchronous) |
| oc_i | input | 1 | Over-current comparator flag (asynchronous) |
| lockout_i | input | 1 | Under-voltage lockout flag (asynchronous) |
| full_load_i | input | 1 | Selects full-load comparator-driven mode |
| headroom_i | input | HW | Headroom code; a lower code gives a longer on-time |
| ton_base_i | input | CW | Base minimum-on count in cycles |
| toff_i | input | CW | Minimum-off count in cycles after over-current |
| hs_en_o | output | 1 | High-side switch enable |
| ls_en_o | output | 1 | Low-side switch enable |
| state_o | output | 3 | State code (0 rest, 1 high, 2 gap, 3 low, 4 forced off, 5/6/7 full-load high/low/gap) |

## Verification
Over-current cut and on-time expiry can fall in the same cycle, and the two send the sequencer to different successors. The bench provokes this by timing a one-cycle over-current pulse so that its synchronized copy lands exactly in the final cycle of a 10-cycle on-time. It then checks that the next state code is 4 and not 2. It also checks that a 4-cycle forced-off window follows, and then a fresh full-length pulse. A second collision, lockout arriving during a live pulse while sag stays high, is judged by both enables falling on the third edge and by a full-length pulse after release.

// File: rtl/pod_pkg.sv
`timescale 1ns/1ps
package pod_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HS    = 3'd1,
        ST_GAP   = 3'd2,
        ST_LS    = 3'd3,
        ST_OCOFF = 3'd4,
        ST_FHS   = 3'd5,
        ST_FLS   = 3'd6,
        ST_FGAP  = 3'd7
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

    typedef struct packed {
        logic full;
        logic lock;
        logic oc;
        logic zc;
        logic sag;
    } flags_t;

    localparam int NFLAGS = $bits(flags_t);

endpackage

// File: rtl/pod_sync.sv
`timescale 1ns/1ps
module pod_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] s_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
                assign stg_d[k] = a_i;
            end else begin : g_next
                assign stg_d[k] = stg_q[k-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[k] <= '0;
                else        stg_q[k] <= stg_d[k];
            end
        end
    endgenerate

    assign s_o = stg_q[STAGES-1];
endmodule

// File: rtl/pod_ontime.sv
`timescale 1ns/1ps
module pod_ontime #(
    parameter int HW = 4,
    parameter int CW = 8
) (
    input  logic [HW-1:0] headroom_i,
    input  logic [CW-1:0] base_i,
    output logic [CW:0]   dur_o
);
    localparam int          OW   = CW + 1;
    localparam logic [HW-1:0] HMAX = '1;

    // Less headroom across the pass device -> longer pulse.
    always_comb begin
        dur_o = {1'b0, base_i} + OW'(HMAX - headroom_i);
    end
endmodule

// File: rtl/pod_oneshot.sv
`timescale 1ns/1ps
module pod_oneshot #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire_i,
    input  logic         clr_i,
    input  logic [W-1:0] dur_i,
    output logic         last_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (fire_i && (cnt_q == '0)) begin
            // Loaded on trigger; ignored while already running.
            cnt_d = (dur_i == '0) ? W'(1) : dur_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/pod_sequencer.sv
`timescale 1ns/1ps
module pod_sequencer
    import pod_pkg::*;
#(
    parameter int HW = 4,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sag_i,
    input  logic          zc_i,
    input  logic          oc_i,
    input  logic          lockout_i,
    input  logic          full_load_i,
    input  logic [HW-1:0] headroom_i,
    input  logic [CW-1:0] ton_base_i,
    input  logic [CW-1:0] toff_i,
    output logic          hs_en_o,
    output logic          ls_en_o,
    output logic [2:0]    state_o
);
    localparam int DW = CW + 1;

    logic [NFLAGS-1:0] raw_flags, sync_flags;
    flags_t            fl;
    logic [DW-1:0]     on_dur, off_dur;
    logic              on_fire, on_clr, on_last;
    logic              off_fire, off_clr, off_last;
    seq_regs_t         regs_d, regs_q;

    assign raw_flags = {full_load_i, lockout_i, oc_i, zc_i, sag_i};

    pod_sync #(.W(NFLAGS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (raw_flags),
        .s_o   (sync_flags)
    );
    assign fl = flags_t'(sync_flags);

    pod_ontime #(.HW(HW), .CW(CW)) u_ontime (
        .headroom_i (headroom_i),
        .base_i     (ton_base_i),
        .dur_o      (on_dur)
    );
    assign off_dur = {1'b0, toff_i};

    pod_oneshot #(.W(DW)) u_on_shot (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (on_fire),
        .clr_i  (on_clr),
        .dur_i  (on_dur),
        .last_o (on_last)
    );

    pod_oneshot #(.W(DW)) u_off_shot (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (off_fire),
        .clr_i  (off_clr),
        .dur_i  (off_dur),
        .last_o (off_last)
    );

    always_comb begin
        regs_d = regs_q;
        if (fl.lock) begin
            regs_d.st = ST_IDLE;
        end else begin
            unique case (regs_q.st)
                ST_IDLE: begin
                    if (fl.full)     regs_d.st = fl.sag ? ST_FHS : ST_FLS;
                    else if (fl.sag) regs_d.st = ST_HS;
                end
                ST_HS: begin
                    // Over-current outranks expiry of the on-time.
                    if (fl.oc)        regs_d.st = ST_OCOFF;
                    else if (on_last) regs_d.st = ST_GAP;
                end
                ST_GAP:   regs_d.st = ST_LS;
                ST_LS:    if (fl.zc) regs_d.st = ST_IDLE;
                ST_OCOFF: if (off_last) regs_d.st = ST_HS;
                ST_FHS: begin
                    if (!fl.full)    regs_d.st = ST_IDLE;
                    else if (!fl.sag) regs_d.st = ST_FGAP;
                end
                ST_FLS: begin
                    if (!fl.full)    regs_d.st = ST_IDLE;
                    else if (fl.sag) regs_d.st = ST_FGAP;
                end
                ST_FGAP: begin
                    if (!fl.full) regs_d.st = ST_IDLE;
                    else          regs_d.st = fl.sag ? ST_FHS : ST_FLS;
                end
                default: regs_d.st = ST_IDLE;
            endcase
        end
    end

    assign on_fire  = (regs_d.st == ST_HS)    && (regs_q.st != ST_HS);
    assign on_clr   = (regs_q.st == ST_HS)    && (regs_d.st != ST_HS);
    assign off_fire = (regs_q.st == ST_HS)    && (regs_d.st == ST_OCOFF);
    assign off_clr  = (regs_q.st == ST_OCOFF) && (regs_d.st != ST_OCOFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{st: ST_IDLE};
        else        regs_q <= regs_d;
    end

    assign hs_en_o = (regs_q.st == ST_HS) || (regs_q.st == ST_FHS);
    assign ls_en_o = (regs_q.st == ST_LS) || (regs_q.st == ST_FLS);
    assign state_o = regs_q.st;
endmodule

// File: rtl/pod_sequencer_chk.sv
`timescale 1ns/1ps
module pod_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lockout_i,
    input logic       hs_en_o,
    input logic       ls_en_o,
    input logic [2:0] state_o
);
    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en_o && ls_en_o));

    assert_hs_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en_o |=> !ls_en_o);

    assert_ls_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en_o |=> !hs_en_o);

    assert_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lockout_i, 3) |-> (!hs_en_o && !ls_en_o));

    assert_ls_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |=> (state_o == 3'd3 || state_o == 3'd0));

    assert_hs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en_o) |-> ($past(state_o) == 3'd0 || $past(state_o) == 3'd4
                            || $past(state_o) == 3'd7));
endmodule

bind pod_sequencer pod_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lockout_i (lockout_i),
    .hs_en_o   (hs_en_o),
    .ls_en_o   (ls_en_o),
    .state_o   (state_o)
);

// File: tb/pod_sequencer_tb.sv
`timescale 1ns/1ps
module pod_sequencer_tb;
    localparam int HW = 4;
    localparam int CW = 8;

    // {headroom, base, expected on-time}
    localparam logic [23:0] VEC [5] = '{
        {4'd15, 8'd3, 12'd3},
        {4'd10, 8'd3, 12'd8},
        {4'd0,  8'd2, 12'd17},
        {4'd15, 8'd0, 12'd1},
        {4'd12, 8'd5, 12'd8}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sag, zc, oc, lock, full;
    logic [HW-1:0] hdr;
    logic [CW-1:0] base, toff;
    logic          hs, ls;
    logic [2:0]    st;
    int            nchk = 0;
    int            nerr = 0;

    always #2.5 clk = ~clk;

    pod_sequencer #(.HW(HW), .CW(CW)) u_dut (
        .clk (clk), .rst_n (rst_n), .sag_i (sag), .zc_i (zc), .oc_i (oc),
        .lockout_i (lock), .full_load_i (full), .headroom_i (hdr),
        .ton_base_i (base), .toff_i (toff),
        .hs_en_o (hs), .ls_en_o (ls), .state_o (st)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_pulse();
        sag = 1'b1;
        repeat (2) @(negedge clk);
        chk(!hs, "R8 sag not yet through synchronizer", hs, 0);
        @(negedge clk);
        chk(hs && st == 3'd1, "R2 high side starts on third edge", st, 1);
        sag = 1'b0;
    endtask

    task automatic count_hs(output int n);
        n = 0;
        while (hs && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_ls();
        chk(st == 3'd2 && !hs && !ls, "R3 dead gap after high side", st, 2);
        @(negedge clk);
        chk(st == 3'd3 && ls, "R3 low side on after gap", st, 3);
        repeat (4) @(negedge clk);
        chk(ls && !hs, "R4 R9 low side held alone until zero current", ls, 1);
        zc = 1'b1;
        @(negedge clk);
        zc = 1'b0;
        @(negedge clk);
        chk(st == 3'd3, "R8 zero-current flag still in synchronizer", st, 3);
        @(negedge clk);
        chk(st == 3'd0 && !hs && !ls, "R4 rest after zero current", st, 0);
        repeat (5) @(negedge clk);
        chk(st == 3'd0, "R4 stays at rest without sag", st, 0);
    endtask

    task automatic oc_run(input int dly);
        int n;
        hdr = 4'd15; base = 8'd10; toff = 8'd4;
        start_pulse();
        repeat (dly) @(negedge clk);
        oc = 1'b1;
        @(negedge clk);
        oc = 1'b0;
        count_hs(n);
        chk(dly + 1 + n == dly + 3, "R5 high side cut after over-current", dly + 1 + n, dly + 3);
        chk(st == 3'd4, "R5 forced-off state (beats expiry)", st, 4);
        n = 0;
        while (st == 3'd4 && n < 200) begin
            n++;
            @(negedge clk);
        end
        chk(n == 4, "R5 minimum-off length", n, 4);
        chk(hs, "R5 high side relaunched", hs, 1);
        count_hs(n);
        chk(n == 10, "R5 fresh full on-time after relaunch", n, 10);
        finish_ls();
    endtask

    initial begin
        int n;
        logic [23:0] v;
        rst_n = 1'b0; sag = 0; zc = 0; oc = 0; lock = 0; full = 0;
        hdr = 4'd15; base = 8'd3; toff = 8'd4;
        repeat (3) @(negedge clk);
        chk(st == 3'd0 && !hs && !ls, "R1 reset state", st, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(st == 3'd0 && !hs && !ls, "R1 rest after reset release", st, 0);

        for (int i = 0; i < 5; i++) begin
            v = VEC[i];
            hdr = v[23:20];
            base = v[19:12];
            start_pulse();
            count_hs(n);
            chk(n == int'(v[11:0]), "R2 on-time from headroom and base", n, int'(v[11:0]));
            finish_ls();
        end

        // R10: headroom change during the pulse is ignored
        hdr = 4'd15; base = 8'd6;
        start_pulse();
        hdr = 4'd0; base = 8'd40;
        count_hs(n);
        chk(n == 6, "R10 running pulse keeps captured length", n, 6);
        finish_ls();
        hdr = 4'd15;

        oc_run(2);
        oc_run(7);

        // R7: lockout during a pulse with sag held
        hdr = 4'd15; base = 8'd20;
        start_pulse();
        sag = 1'b1; lock = 1'b1;
        repeat (3) @(negedge clk);
        chk(st == 3'd0 && !hs && !ls, "R7 lockout forces rest", st, 0);
        repeat (8) @(negedge clk);
        chk(st == 3'd0 && !hs && !ls, "R7 rest held despite sag", st, 0);
        lock = 1'b0;
        repeat (3) @(negedge clk);
        chk(hs && st == 3'd1, "R7 pulse restarts after release", st, 1);
        sag = 1'b0;
        count_hs(n);
        chk(n == 20, "R7 full pulse after release", n, 20);
        finish_ls();

        // R6: full-load comparator-driven mode
        full = 1'b1; sag = 1'b0;
        repeat (3) @(negedge clk);
        chk(st == 3'd6 && ls && !hs, "R6 low side while no sag", st, 6);
        sag = 1'b1;
        repeat (3) @(negedge clk);
        chk(st == 3'd7 && !hs && !ls, "R6 gap before high side", st, 7);
        @(negedge clk);
        chk(st == 3'd5 && hs, "R6 high side while sag", st, 5);
        repeat (25) @(negedge clk);
        chk(hs && !ls, "R6 high side not limited by one-shot", hs, 1);
        sag = 1'b0;
        repeat (3) @(negedge clk);
        chk(st == 3'd7 && !hs && !ls, "R6 gap before low side", st, 7);
        @(negedge clk);
        chk(st == 3'd6 && ls, "R6 low side again", st, 6);
        full = 1'b0;
        repeat (3) @(negedge clk);
        chk(st == 3'd0 && !hs && !ls, "R6 leaving full-load goes to rest", st, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule